// File: doc/BRIEF.md
# Periodic start-split pipeline tracker

This block sits in the high-speed side of a hub translator and holds periodic start-split requests until the full/low-speed handler can run them. Each accepted request is stamped with the microframe it arrived in. It becomes eligible to run only once the next microframe has begun, so no downstream transaction can start too early. Eligible requests go to the downstream handler one at a time, oldest first, and only while the complete-split result stage reports room.

Time also clears the buffer. At every microframe start, a request that is four or more microframes old is discarded. If that request is already running downstream, it is aborted. The full-speed end-of-frame event aborts the running transaction and discards every buffered request except those that arrived during the current microframe 7. A discarded or aborted request never produces a complete-split result, so the host later sees a not-yet answer.

For an aborted IN the downstream handler must withhold its handshake and drain any data packet still in flight. For an aborted OUT it must stop sending data and force a bit-stuffing error. The tracker tells it which of the two to do.

Top module: `ss_tracker`

## Requirements
- R1: A request accepted in microframe X is not marked eligible until the first `uf_tick_i` after it is accepted. `disp_valid_o` can rise for it no earlier than the cycle after that tick. No dispatch happens in a tick cycle or in an end-of-frame cycle.
- R2: Eligible requests are dispatched in arrival order. While one transaction is running, no other is dispatched. A running transaction ends on `ds_done_i` or when it is aborted.
- R3: In a `uf_tick_i` cycle, every request that was never dispatched and whose age is 4 or more is discarded. Age is the new microframe stamp minus the arrival stamp, taken modulo 16. The number discarded appears on `free_cnt_o` in that same cycle.
- R4: In a `uf_tick_i` cycle, a running transaction of age 4 or more is aborted. This applies to interrupt and isochronous transactions alike.
- R5: When `fs_eof_i` is high:
  - the running transaction is aborted;
  - every request that was never dispatched is discarded and counted on `free_cnt_o`, except those stamped with the current microframe when that microframe is 7;
  - the requests kept in this way are dispatched after the next tick.
- R6: No dispatch happens while `cs_room_i` is low. A waiting request is dispatched in the first cycle that `cs_room_i` is high.
- R7: `ss_ready_o` is low, and a request offered in that cycle is not accepted, in any of three cases:
  - the buffer already holds DEPTH (32) requests;
  - PER_UF (16) requests have already been accepted in the current microframe, a tick in the same cycle clearing that count;
  - the buffered bytes plus `ss_len_i` would exceed BYTE_MAX (752).
- R8: `cs_push_o` pulses with `cs_push_tag_o` on `ds_done_i` for a running transaction. It stays low for a transaction that is aborted, including when `ds_done_i` falls in the abort cycle, and for a discarded request.
- R9: An abort of an IN transaction (`ss_is_in_i`=1) pulses `abort_in_o` (withhold handshake, drain data). An abort of an OUT transaction (`ss_is_in_i`=0) pulses `abort_out_o` (stop data, force a stuff error). The two pulses are never high together.
- R10: Stamps are the 3-bit microframe number plus a frame-wrap bit. The wrap bit toggles whenever the new microframe number is lower than the previous one, so age stays correct across a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uf_tick_i | input | 1 | Start of a new microframe |
| uf_num_i | input | 3 | Number of the new microframe, valid with the tick |
| fs_eof_i | input | 1 | Full-speed end-of-frame event |
| ss_valid_i | input | 1 | Start-split request offered |
| ss_is_in_i | input | 1 | 1 = IN transaction, 0 = OUT |
| ss_len_i | input | 10 | Buffered payload bytes of the request |
| ss_tag_i | input | 6 | Endpoint tag |
| ss_ready_o | output | 1 | Request accepted this cycle when valid |
| cs_room_i | input | 1 | Complete-split stage can take a result |
| ds_done_i | input | 1 | Downstream transaction finished with a result |
| disp_valid_o | output | 1 | Dispatch pulse to the downstream handler |
| disp_tag_o | output | 6 | Tag of the dispatched request |
| disp_is_in_o | output | 1 | Direction of the dispatched request |
| disp_len_o | output | 10 | Length of the dispatched request |
| cs_push_o | output | 1 | Write a result into the complete-split stage |
| cs_push_tag_o | output | 6 | Tag of that result |
| abort_in_o | output | 1 | Abort the running IN transaction |
| abort_out_o | output | 1 | Abort the running OUT transaction |
| free_cnt_o | output | 6 | Requests discarded this cycle without dispatch |

## Verification
Two functions can meet in one cycle:
- the downstream handler can report completion in the very cycle that a microframe tick ages its transaction to four;
- an end-of-frame event can hit while a transaction is running and other requests wait.

The bench drives `ds_done_i` together with the fourth tick and expects `abort_out_o` high with `cs_push_o` low. It also raises `fs_eof_i` with a transaction running, one request waiting from microframe 6 and one from microframe 7. It expects one abort and a discard count of one. Only the microframe-7 request may be dispatched after the following tick.

// File: rtl/ss_pkg.sv
package ss_pkg;
  parameter int unsigned SS_LEN_W   = 10;
  parameter int unsigned SS_TAG_W   = 6;
  parameter int unsigned SS_STAMP_W = 4;
  parameter int unsigned SS_UF_W    = SS_STAMP_W - 1;

  typedef logic [SS_STAMP_W-1:0] stamp_t;

  typedef struct packed {
    logic                pend;
    logic                act;
    stamp_t              stamp;
    logic                is_in;
    logic [SS_LEN_W-1:0] len;
    logic [SS_TAG_W-1:0] tag;
  } ss_ent_t;

  function automatic stamp_t stamp_age(stamp_t now, stamp_t then);
    return now - then;
  endfunction
endpackage

// File: rtl/ss_uframe_clock.sv
module ss_uframe_clock
  import ss_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [SS_UF_W-1:0] num_i,
  output stamp_t             now_o
);
  logic [SS_UF_W-1:0] uf_q;
  logic               wrap_q;
  logic               wrap_n;

  // frame wrap flips whenever the microframe number steps backwards
  always_comb begin
    wrap_n = wrap_q;
    now_o  = {wrap_q, uf_q};
    if (tick_i) begin
      wrap_n = wrap_q ^ (num_i < uf_q);
      now_o  = {wrap_n, num_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q   <= '0;
      wrap_q <= 1'b0;
    end else begin
      uf_q   <= now_o[SS_UF_W-1:0];
      wrap_q <= now_o[SS_STAMP_W-1];
    end
  end
endmodule

// File: rtl/ss_pick.sv
module ss_pick #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: queue order equals arrival order
  always_comb begin
    found_o = |cand_i;
    idx_o   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ss_queue.sv
module ss_queue
  import ss_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DEPTH-1:0]      keep_i,
  input  ss_ent_t [DEPTH-1:0]   upd_i,
  input  logic                  push_i,
  input  ss_ent_t               push_ent_i,
  output ss_ent_t [DEPTH-1:0]   ent_o,
  output logic [CNT_W-1:0]      cnt_o
);
  ss_ent_t [DEPTH-1:0] ent_q, ent_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [CNT_W-1:0]    r;

  // compact surviving entries toward index 0, then append the arrival
  always_comb begin
    ent_n = '0;
    r     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep_i[i]) begin
        ent_n[r[IDX_W-1:0]] = upd_i[i];
        r = r + 1'b1;
      end
    end
    cnt_n = r;
    if (push_i && (r < CNT_W'(DEPTH))) begin
      ent_n[r[IDX_W-1:0]] = push_ent_i;
      cnt_n = r + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else begin
      ent_q <= ent_n;
      cnt_q <= cnt_n;
    end
  end

  assign ent_o = ent_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/ss_tracker.sv
module ss_tracker
  import ss_pkg::*;
#(
  parameter  int unsigned DEPTH    = 32,
  parameter  int unsigned PER_UF   = 16,
  parameter  int unsigned BYTE_MAX = 752,
  parameter  int unsigned MAX_AGE  = 4,
  localparam int unsigned LEN_W    = SS_LEN_W,
  localparam int unsigned TAG_W    = SS_TAG_W,
  localparam int unsigned UF_W     = SS_UF_W,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uf_tick_i,
  input  logic [UF_W-1:0]  uf_num_i,
  input  logic             fs_eof_i,
  input  logic             ss_valid_i,
  input  logic             ss_is_in_i,
  input  logic [LEN_W-1:0] ss_len_i,
  input  logic [TAG_W-1:0] ss_tag_i,
  output logic             ss_ready_o,
  input  logic             cs_room_i,
  input  logic             ds_done_i,
  output logic             disp_valid_o,
  output logic [TAG_W-1:0] disp_tag_o,
  output logic             disp_is_in_o,
  output logic [LEN_W-1:0] disp_len_o,
  output logic             cs_push_o,
  output logic [TAG_W-1:0] cs_push_tag_o,
  output logic             abort_in_o,
  output logic             abort_out_o,
  output logic [CNT_W-1:0] free_cnt_o
);
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam int unsigned UFC_W   = $clog2(PER_UF + 1);
  localparam int unsigned BYTES_W = LEN_W + $clog2(DEPTH) + 1;
  localparam stamp_t      AGE_LIM = stamp_t'(MAX_AGE);
  localparam logic [UF_W-1:0] LAST_UF = {UF_W{1'b1}};

  stamp_t              now;
  ss_ent_t [DEPTH-1:0] ent;
  ss_ent_t [DEPTH-1:0] upd;
  ss_ent_t             push_ent;
  logic [CNT_W-1:0]    cnt;
  logic [DEPTH-1:0]    valid_v, act_v, pend_v, kill_v, done_v, keep_v, freed_v, disp_sel;
  logic                push;
  logic                act_any, kill_act;
  logic                act_found, pend_found, disp_ok;
  logic [IDX_W-1:0]    act_idx, pend_idx;
  logic [BYTES_W-1:0]  bytes_sum;
  logic [UFC_W-1:0]    uf_cnt_q, uf_cnt_eff;
  logic [CNT_W-1:0]    free_sum;

  ss_uframe_clock u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (uf_tick_i),
    .num_i  (uf_num_i),
    .now_o  (now)
  );

  ss_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .keep_i     (keep_v),
    .upd_i      (upd),
    .push_i     (push),
    .push_ent_i (push_ent),
    .ent_o      (ent),
    .cnt_o      (cnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    stamp_t age;
    logic   old, eof_kill, keep_eof;
    assign valid_v[i] = CNT_W'(i) < cnt;
    assign age        = stamp_age(now, ent[i].stamp);
    assign old        = uf_tick_i && (age >= AGE_LIM);
    // arrivals of the current last microframe survive end of frame
    assign keep_eof   = (ent[i].stamp == now) && (now[UF_W-1:0] == LAST_UF);
    assign eof_kill   = fs_eof_i && !keep_eof;
    assign kill_v[i]  = valid_v[i] && (old || eof_kill);
    assign act_v[i]   = valid_v[i] && ent[i].act;
    assign pend_v[i]  = valid_v[i] && ent[i].pend && !ent[i].act;
    assign done_v[i]  = act_v[i] && ds_done_i && !kill_v[i];
    assign keep_v[i]  = valid_v[i] && !kill_v[i] && !done_v[i];
    assign freed_v[i] = kill_v[i] && !ent[i].act;
    assign disp_sel[i] = disp_ok && (pend_idx == IDX_W'(i));
    assign upd[i] = '{pend:  ent[i].pend | uf_tick_i,
                      act:   ent[i].act | disp_sel[i],
                      stamp: ent[i].stamp,
                      is_in: ent[i].is_in,
                      len:   ent[i].len,
                      tag:   ent[i].tag};
  end

  ss_pick #(.DEPTH(DEPTH)) u_pick_act (
    .cand_i  (act_v),
    .found_o (act_found),
    .idx_o   (act_idx)
  );

  ss_pick #(.DEPTH(DEPTH)) u_pick_pend (
    .cand_i  (pend_v),
    .found_o (pend_found),
    .idx_o   (pend_idx)
  );

  assign act_any  = act_found;
  assign kill_act = |(act_v & kill_v);

  // dispatch uses eligibility registered before this cycle; never in a tick or EOF cycle
  assign disp_ok      = !uf_tick_i && !fs_eof_i && !act_any && cs_room_i && pend_found;
  assign disp_valid_o = disp_ok;
  assign disp_tag_o   = ent[pend_idx].tag;
  assign disp_is_in_o = ent[pend_idx].is_in;
  assign disp_len_o   = ent[pend_idx].len;

  assign abort_in_o    = kill_act && ent[act_idx].is_in;
  assign abort_out_o   = kill_act && !ent[act_idx].is_in;
  assign cs_push_o     = |done_v;
  assign cs_push_tag_o = ent[act_idx].tag;

  always_comb begin
    free_sum  = '0;
    bytes_sum = '0;
    for (int i = 0; i < DEPTH; i++) begin
      free_sum = free_sum + CNT_W'(freed_v[i]);
      if (valid_v[i]) bytes_sum = bytes_sum + BYTES_W'(ent[i].len);
    end
  end
  assign free_cnt_o = free_sum;

  assign uf_cnt_eff = uf_tick_i ? '0 : uf_cnt_q;
  assign ss_ready_o = (cnt < CNT_W'(DEPTH)) &&
                      (uf_cnt_eff < UFC_W'(PER_UF)) &&
                      ((bytes_sum + BYTES_W'(ss_len_i)) <= BYTES_W'(BYTE_MAX));
  assign push       = ss_valid_i && ss_ready_o;
  assign push_ent   = '{pend: 1'b0, act: 1'b0, stamp: now,
                        is_in: ss_is_in_i, len: ss_len_i, tag: ss_tag_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uf_cnt_q <= '0;
    else         uf_cnt_q <= uf_cnt_eff + UFC_W'(push);
  end
endmodule

// File: rtl/ss_tracker_chk.sv
module ss_tracker_chk #(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned BYTE_MAX = 752,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned BYTES_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               uf_tick_i,
  input logic               fs_eof_i,
  input logic               cs_room_i,
  input logic               disp_valid_o,
  input logic               cs_push_o,
  input logic               abort_in_o,
  input logic               abort_out_o,
  input logic [CNT_W-1:0]   free_cnt_o,
  input logic [DEPTH-1:0]   act_v,
  input logic [DEPTH-1:0]   pend_v,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [BYTES_W-1:0] bytes_i,
  input logic               push_i
);
  p_defer_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !uf_tick_i && (pend_v == '0)) |=> !disp_valid_o);

  p_single_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_v));

  p_free_timed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt_o != '0) |-> (uf_tick_i || fs_eof_i));

  p_room_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> cs_room_i);

  p_capacity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= CNT_W'(DEPTH)) && (bytes_i <= BYTES_W'(BYTE_MAX)));

  p_no_push_on_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_in_o || abort_out_o) |-> !cs_push_o);

  p_abort_kind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_in_o && abort_out_o));
endmodule

bind ss_tracker ss_tracker_chk #(
  .DEPTH(DEPTH), .BYTE_MAX(BYTE_MAX), .CNT_W(CNT_W), .BYTES_W(BYTES_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .uf_tick_i    (uf_tick_i),
  .fs_eof_i     (fs_eof_i),
  .cs_room_i    (cs_room_i),
  .disp_valid_o (disp_valid_o),
  .cs_push_o    (cs_push_o),
  .abort_in_o   (abort_in_o),
  .abort_out_o  (abort_out_o),
  .free_cnt_o   (free_cnt_o),
  .act_v        (act_v),
  .pend_v       (pend_v),
  .cnt_i        (cnt),
  .bytes_i      (bytes_sum),
  .push_i       (push)
);

// File: tb/ss_tracker_bench.sv
`timescale 1ns/1ps
module ss_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uf_tick = 1'b0;
  logic [2:0] uf_num = '0;
  logic       fs_eof = 1'b0;
  logic       ss_valid = 1'b0;
  logic       ss_is_in = 1'b0;
  logic [9:0] ss_len = '0;
  logic [5:0] ss_tag = '0;
  logic       ss_ready;
  logic       cs_room = 1'b1;
  logic       ds_done = 1'b0;
  logic       disp_valid;
  logic [5:0] disp_tag;
  logic       disp_is_in;
  logic [9:0] disp_len;
  logic       cs_push;
  logic [5:0] cs_push_tag;
  logic       abort_in, abort_out;
  logic [5:0] free_cnt;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  ss_tracker u_ss_tracker (
    .clk_i(clk), .rst_ni(rst_n), .uf_tick_i(uf_tick), .uf_num_i(uf_num),
    .fs_eof_i(fs_eof), .ss_valid_i(ss_valid), .ss_is_in_i(ss_is_in),
    .ss_len_i(ss_len), .ss_tag_i(ss_tag), .ss_ready_o(ss_ready),
    .cs_room_i(cs_room), .ds_done_i(ds_done), .disp_valid_o(disp_valid),
    .disp_tag_o(disp_tag), .disp_is_in_o(disp_is_in), .disp_len_o(disp_len),
    .cs_push_o(cs_push), .cs_push_tag_o(cs_push_tag), .abort_in_o(abort_in),
    .abort_out_o(abort_out), .free_cnt_o(free_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // step to just after the next rising edge and drop one-cycle inputs
  task automatic nxt();
    @(posedge clk);
    #1;
    uf_tick = 1'b0; fs_eof = 1'b0; ss_valid = 1'b0; ds_done = 1'b0;
  endtask

  task automatic do_idle();
    nxt(); #1;
  endtask

  task automatic do_tick(input logic [2:0] n);
    nxt(); uf_tick = 1'b1; uf_num = n; #1;
  endtask

  task automatic do_ss(input int tag, input logic is_in, input int len);
    nxt(); ss_valid = 1'b1; ss_tag = 6'(tag); ss_is_in = is_in; ss_len = 10'(len); #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; uf_tick = 1'b0; fs_eof = 1'b0; ss_valid = 1'b0;
    ds_done = 1'b0; cs_room = 1'b1; uf_num = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(); #1;
    chk("R7", "ready after reset", int'(ss_ready), 1);
    chk("R2", "no dispatch after reset", int'(disp_valid), 0);
    chk("R3", "free count after reset", int'(free_cnt), 0);
    chk("R9", "no abort after reset", int'(abort_in | abort_out), 0);
  endtask

  task automatic t_defer();
    do_reset();
    do_ss(1, 1'b1, 8);
    chk("R1", "accepted", int'(ss_ready), 1);
    do_idle(); chk("R1", "no dispatch same microframe", int'(disp_valid), 0);
    do_idle(); chk("R1", "no dispatch same microframe", int'(disp_valid), 0);
    do_tick(3'd1); chk("R1", "no dispatch in tick cycle", int'(disp_valid), 0);
    do_idle();
    chk("R1", "dispatch after tick", int'(disp_valid), 1);
    chk("R1", "dispatch tag", int'(disp_tag), 1);
  endtask

  task automatic t_order();
    do_reset();
    do_ss(2, 1'b0, 4);
    do_ss(3, 1'b0, 4);
    do_tick(3'd1);
    do_idle();
    chk("R2", "first dispatch", int'(disp_valid), 1);
    chk("R2", "oldest first", int'(disp_tag), 2);
    do_idle(); chk("R2", "busy blocks dispatch", int'(disp_valid), 0);
    nxt(); ds_done = 1'b1; #1;
    chk("R8", "result pushed", int'(cs_push), 1);
    chk("R8", "result tag", int'(cs_push_tag), 2);
    chk("R2", "no dispatch in done cycle", int'(disp_valid), 0);
    do_idle();
    chk("R2", "second dispatch", int'(disp_valid), 1);
    chk("R2", "second tag", int'(disp_tag), 3);
  endtask

  task automatic t_room();
    do_reset();
    cs_room = 1'b0;
    do_ss(4, 1'b1, 8);
    do_tick(3'd1);
    do_idle(); chk("R6", "held without room", int'(disp_valid), 0);
    do_idle(); chk("R6", "still held", int'(disp_valid), 0);
    nxt(); cs_room = 1'b1; #1;
    chk("R6", "dispatch on room", int'(disp_valid), 1);
    chk("R6", "tag", int'(disp_tag), 4);
  endtask

  task automatic t_age_free();
    do_reset();
    cs_room = 1'b0;
    do_ss(10, 1'b0, 8);
    do_ss(11, 1'b0, 8);
    do_tick(3'd1); chk("R3", "age1 kept", int'(free_cnt), 0);
    do_tick(3'd2); chk("R3", "age2 kept", int'(free_cnt), 0);
    do_tick(3'd3); chk("R3", "age3 kept", int'(free_cnt), 0);
    do_tick(3'd4); chk("R3", "age4 freed", int'(free_cnt), 2);
    nxt(); cs_room = 1'b1; #1;
    chk("R3", "freed not dispatched", int'(disp_valid), 0);
  endtask

  task automatic t_abort_in();
    do_reset();
    do_ss(5, 1'b1, 8);
    do_tick(3'd1);
    do_idle(); chk("R4", "dispatched", int'(disp_valid), 1);
    do_tick(3'd2); chk("R4", "no abort age2", int'(abort_in), 0);
    do_tick(3'd3); chk("R4", "no abort age3", int'(abort_in), 0);
    do_tick(3'd4);
    chk("R4", "abort at age4", int'(abort_in), 1);
    chk("R9", "IN abort kind", int'(abort_out), 0);
    chk("R3", "abort not counted free", int'(free_cnt), 0);
    nxt(); ds_done = 1'b1; #1;
    chk("R8", "no push after abort", int'(cs_push), 0);
  endtask

  task automatic t_collide();
    do_reset();
    do_ss(6, 1'b0, 20);
    do_tick(3'd1);
    do_idle();
    do_tick(3'd2);
    do_tick(3'd3);
    nxt(); uf_tick = 1'b1; uf_num = 3'd4; ds_done = 1'b1; #1;
    chk("R9", "OUT abort kind", int'(abort_out), 1);
    chk("R8", "abort beats done", int'(cs_push), 0);
    do_idle(); chk("R8", "queue empty after abort", int'(disp_valid), 0);
  endtask

  task automatic t_eof();
    do_reset();
    do_tick(3'd6);
    do_ss(7, 1'b0, 10);
    do_ss(9, 1'b1, 10);
    do_tick(3'd7); chk("R1", "no dispatch in tick", int'(disp_valid), 0);
    do_idle();
    chk("R5", "dispatch tag7", int'(disp_valid), 1);
    chk("R5", "tag", int'(disp_tag), 7);
    do_ss(8, 1'b1, 10);
    nxt(); fs_eof = 1'b1; #1;
    chk("R5", "eof aborts OUT", int'(abort_out), 1);
    chk("R5", "eof frees one", int'(free_cnt), 1);
    do_tick(3'd0); chk("R5", "nothing freed at tick", int'(free_cnt), 0);
    do_idle();
    chk("R5", "uf7 arrival survives", int'(disp_valid), 1);
    chk("R5", "survivor tag", int'(disp_tag), 8);
    nxt(); ds_done = 1'b1; #1;
    chk("R8", "survivor pushed", int'(cs_push), 1);
    chk("R8", "push tag", int'(cs_push_tag), 8);
    do_idle(); chk("R5", "freed entry gone", int'(disp_valid), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    cs_room = 1'b0;
    do_tick(3'd6);
    do_ss(12, 1'b0, 8);
    do_tick(3'd7); chk("R10", "age1", int'(free_cnt), 0);
    do_tick(3'd0); chk("R10", "age2 over wrap", int'(free_cnt), 0);
    do_tick(3'd1); chk("R10", "age3 over wrap", int'(free_cnt), 0);
    do_tick(3'd2); chk("R10", "age4 over wrap", int'(free_cnt), 1);
  endtask

  task automatic t_capacity();
    do_reset();
    cs_room = 1'b0;
    nxt(); ss_valid = 1'b1; ss_len = 10'd752; ss_tag = 6'd20; #1;
    chk("R7", "752 bytes fit", int'(ss_ready), 1);
    nxt(); ss_valid = 1'b1; ss_len = 10'd1; #1;
    chk("R7", "byte limit", int'(ss_ready), 0);
    do_reset();
    cs_room = 1'b0;
    for (int k = 0; k < 16; k++) do_ss(k, 1'b0, 1);
    nxt(); ss_valid = 1'b1; ss_len = 10'd1; #1;
    chk("R7", "per-microframe limit", int'(ss_ready), 0);
    nxt(); uf_tick = 1'b1; uf_num = 3'd1; ss_valid = 1'b1; ss_len = 10'd1; #1;
    chk("R7", "limit cleared by tick", int'(ss_ready), 1);
    for (int k = 0; k < 15; k++) do_ss(k + 40, 1'b0, 1);
    nxt(); uf_tick = 1'b1; uf_num = 3'd2; ss_valid = 1'b1; ss_len = 10'd1; #1;
    chk("R7", "depth limit", int'(ss_ready), 0);
  endtask

  initial begin
    t_reset_state();
    t_defer();
    t_order();
    t_room();
    t_age_free();
    t_abort_in();
    t_collide();
    t_eof();
    t_wrap();
    t_capacity();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule